// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers several peripheral interrupt lines into a single 16-bit pending register. It qualifies that register with a 16-bit enable mask that software writes, and it drives one active-low request line toward a host processor input that senses falling edges. Each source input is brought into the clock domain through a two-stage synchroniser. A rising edge on a synchronised source latches the matching pending bit, and that bit holds until software clears it.

Software reads and writes three registers through a plain 16-bit port. Address 0 is the pending register. Writing it clears every bit written as 0 and keeps every bit written as 1. Address 1 is the enable mask. Address 2 is a read-only index register that gives the lowest-numbered bit that is both pending and enabled, or 16'hFFFF when no such bit exists. Address 3 reads as zero.

Only the source positions set in the `SRC_PRESENT` parameter are connected; by default these are bits 2, 3 and 4. A small state machine drives the request line. Its states are REQ_IDLE (line high) and REQ_ASSERT (line low). The transition REQ_IDLE→REQ_ASSERT is taken when any enabled bit is pending. The transition REQ_ASSERT→REQ_IDLE is taken when none is pending. Once every pending enabled bit is cleared, the line therefore returns high, and each later event produces a fresh falling edge.

Top module: `int_cascade_agg`

## Requirements
- R1: After reset the pending register and the mask read 0, the index register reads 16'hFFFF and `irq_n` is 1.
- R2: When a connected source goes from 0 to 1, its pending bit reads 1 after the third rising clock edge following the input change, and not after the second. A source held at 1 does not set its bit again after the bit is cleared.
- R3: A write to address 0 clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R4: When a source edge and a write that clears the same bit land on the same clock edge, the bit ends up set.
- R5: A write to address 1 stores the mask. The mask keeps its value across any other access, and reading it back returns the stored value.
- R6: Unconnected positions (bits outside 2..4 by default) never become pending, and they read as 0 in both the pending register and the mask.
- R7: `irq_n` goes to 0 one clock edge after (pending AND mask) becomes non-zero. It returns to 1 one clock edge after that value becomes zero.
- R8: A pending bit whose mask bit is 0 stays readable in the pending register but does not drive `irq_n` low.
- R9: Address 2 reads the lowest index i for which both pending[i] and mask[i] are 1, or 16'hFFFF if there is none. Writes to address 2 change nothing.
- R10: Writing 0 to the mask and then 0 to the pending register leaves both at 0 and `irq_n` at 1.
- R11: After `irq_n` returns to 1, a new enabled event drives it to 0 again, so the host sees a fresh falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 16 | Raw peripheral interrupt lines, one per bit position |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 index, 3 reserved |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register (combinational) |
| irq_n | output | 1 | Combined active-low request to the host |

## Verification
A source change reaches the pending register on the third rising edge after it: two synchroniser stages, then the edge-detect latch. `irq_n` follows one edge after that, on the fourth. A register write takes effect on the edge that samples it, and `irq_n` follows one edge later. The index register and read data are combinational, so they are valid right after the write edge. The bench drives inputs and samples outputs on falling clock edges, and counts those edges explicitly. It checks that each result is absent one sample before its due edge and present right after it. The same-edge race between a set and a clear is staged by counting edges so that the write strobe meets the detected edge.

// File: rtl/int_agg_pkg.sv
package int_agg_pkg;

    typedef enum logic [1:0] {
        ADDR_PEND  = 2'd0,
        ADDR_MASK  = 2'd1,
        ADDR_INDEX = 2'd2,
        ADDR_RSVD  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ASSERT = 1'b1
    } req_state_e;

endpackage

// File: rtl/int_edge_sync.sv
module int_edge_sync #(
    parameter int NUM_SRC     = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_SRC-1:0] SRC_PRESENT = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_SRC-1:0] rise_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [CHAIN_W-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN_W-2:0], src_in[i]};
            end
        end

        if (SRC_PRESENT[i]) begin : g_live
            // Newest synchronised sample high, one sample older low.
            assign rise_o[i] = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
        end else begin : g_tied
            assign rise_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/int_status_regs.sv
module int_status_regs #(
    parameter int NUM_SRC = 16,
    parameter logic [NUM_SRC-1:0] SRC_PRESENT = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic               wr_pend,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q
);

    logic [NUM_SRC-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (wr_pend) begin
            pend_d = pend_d & wr_data;
        end
        // Applied after the clear so a coincident edge is not lost.
        pend_d = (pend_d | rise_i) & SRC_PRESENT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (wr_mask) begin
                mask_q <= wr_data & SRC_PRESENT;
            end
        end
    end

endmodule

// File: rtl/int_prio_index.sv
module int_prio_index #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 16
) (
    input  logic [NUM_SRC-1:0] active_i,
    output logic [IDX_W-1:0]   index_o
);

    always_comb begin
        index_o = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active_i[i]) begin
                index_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/int_req_fsm.sv
module int_req_fsm
    import int_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_active,
    output logic irq_n
);

    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:   if (any_active)  state_d = REQ_ASSERT;
            REQ_ASSERT: if (!any_active) state_d = REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            REQ_ASSERT: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/int_cascade_agg.sv
module int_cascade_agg
    import int_agg_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] SRC_PRESENT = 16'h001C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_in,
    input  logic [1:0]        reg_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    localparam int NUM_SRC = DATA_W;

    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] active;
    logic [DATA_W-1:0]  index_val;
    logic               wr_pend;
    logic               wr_mask;
    reg_addr_e          sel;

    assign sel     = reg_addr_e'(reg_addr);
    assign wr_pend = wr_en && (sel == ADDR_PEND);
    assign wr_mask = wr_en && (sel == ADDR_MASK);
    assign active  = pend_q & mask_q;

    int_edge_sync #(
        .NUM_SRC    (NUM_SRC),
        .SYNC_STAGES(SYNC_STAGES),
        .SRC_PRESENT(SRC_PRESENT)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_in(src_in),
        .rise_o(rise)
    );

    int_status_regs #(
        .NUM_SRC    (NUM_SRC),
        .SRC_PRESENT(SRC_PRESENT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .wr_pend(wr_pend),
        .wr_mask(wr_mask),
        .wr_data(wr_data),
        .pend_q (pend_q),
        .mask_q (mask_q)
    );

    int_prio_index #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (DATA_W)
    ) u_index (
        .active_i(active),
        .index_o (index_val)
    );

    int_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_active(|active),
        .irq_n     (irq_n)
    );

    always_comb begin
        unique case (sel)
            ADDR_PEND:  rd_data = pend_q;
            ADDR_MASK:  rd_data = mask_q;
            ADDR_INDEX: rd_data = index_val;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/int_cascade_agg_chk.sv
module int_cascade_agg_chk #(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_pend,
    input logic               wr_mask,
    input logic [NUM_SRC-1:0] wr_data,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] index_val,
    input logic               irq_n
);

    logic [NUM_SRC-1:0] act;
    assign act = pend_q & mask_q;

    // R3
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && rise == '0) |=> pend_q == ($past(pend_q) & $past(wr_data)));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> pend_q == ($past(pend_q) | $past(rise)));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

    // R7
    req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0) |=> !irq_n);

    // R7
    req_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |=> irq_n);

    // R9
    index_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |-> index_val == '1);

    // R9
    index_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act != '0) |-> (((act >> index_val) & NUM_SRC'(1)) == NUM_SRC'(1)
            && (act & ((NUM_SRC'(1) << index_val) - NUM_SRC'(1))) == '0));

endmodule

bind int_cascade_agg int_cascade_agg_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pend  (wr_pend),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .rise     (rise),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .index_val(index_val),
    .irq_n    (irq_n)
);

// File: tb/int_cascade_agg_test.sv
`timescale 1ns/1ps
module int_cascade_agg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic [1:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_n;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_cascade_agg uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .reg_addr(reg_addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_n   (irq_n)
    );

    // Row: mask, source pulse, expected pending, expected irq_n, expected index
    localparam logic [64:0] VEC [0:5] = '{
        {16'h001C, 16'h0004, 16'h0004, 1'b0, 16'h0002},
        {16'h001C, 16'h0018, 16'h0018, 1'b0, 16'h0003},
        {16'h0010, 16'h000C, 16'h000C, 1'b1, 16'hFFFF},
        {16'h0008, 16'h001C, 16'h001C, 1'b0, 16'h0003},
        {16'hFFFF, 16'hFFE3, 16'h0000, 1'b1, 16'hFFFF},
        {16'h0014, 16'h0014, 16'h0014, 1'b0, 16'h0002}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a;
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic pulse(input logic [15:0] bits);
        src_in = bits;
        cyc(3);
        src_in = '0;
        cyc(3);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(2'd0, d); check("R1 pending", d, 16'h0000);
        rd(2'd1, d); check("R1 mask", d, 16'h0000);
        rd(2'd2, d); check("R1 index", d, 16'hFFFF);
        check("R1 irq_n", irq_n, 1'b1);

        // Table walk: R8 R9 R6 over several mask/source patterns
        foreach (VEC[k]) begin
            wr(2'd1, 16'h0000);
            wr(2'd0, 16'h0000);
            wr(2'd1, VEC[k][64:49]);
            pulse(VEC[k][48:33]);
            rd(2'd0, d); check($sformatf("R8/R6 row%0d pending", k), d, VEC[k][32:17]);
            check($sformatf("R8 row%0d irq_n", k), irq_n, VEC[k][16]);
            rd(2'd2, d); check($sformatf("R9 row%0d index", k), d, VEC[k][15:0]);
        end

        // R10 init sequence
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        cyc(1);
        rd(2'd0, d); check("R10 pending", d, 16'h0000);
        rd(2'd1, d); check("R10 mask", d, 16'h0000);
        check("R10 irq_n", irq_n, 1'b1);

        // R5 R6 mask readback holds only connected bits
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R6 mask readback", d, 16'h001C);
        wr(2'd1, 16'h0014);
        wr(2'd0, 16'hFFFF);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'hFFFF);
        rd(2'd1, d); check("R5 mask held", d, 16'h0014);

        // R2 latency: set at third edge, not second
        src_in = 16'h0004;
        cyc(2);
        rd(2'd0, d); check("R2 not yet set", d, 16'h0000);
        cyc(1);
        rd(2'd0, d); check("R2 set at third edge", d, 16'h0004);
        check("R7 irq_n still high", irq_n, 1'b1);
        cyc(1);
        check("R7 irq_n low", irq_n, 1'b0);

        // R9 write to index ignored
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R9 index unaffected by write", d, 16'h0002);
        rd(2'd0, d); check("R9 pending unaffected by write", d, 16'h0004);

        // R3 write of ones keeps; bit held high is edge only
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); check("R3 ones keep", d, 16'h0004);
        wr(2'd0, 16'hFFFB);
        rd(2'd0, d); check("R3 zero clears", d, 16'h0000);
        check("R7 irq_n low right after clear edge", irq_n, 1'b0);
        cyc(1);
        check("R7 irq_n high one edge later", irq_n, 1'b1);
        cyc(4);
        rd(2'd0, d); check("R2 level held does not reset", d, 16'h0000);
        src_in = '0;
        cyc(3);

        // R11 fresh falling edge
        src_in = 16'h0010;
        cyc(3);
        check("R11 irq_n high before", irq_n, 1'b1);
        cyc(1);
        check("R11 irq_n low again", irq_n, 1'b0);
        rd(2'd2, d); check("R9 index bit4", d, 16'h0004);
        src_in = '0;
        wr(2'd0, 16'h0000);
        cyc(2);

        // R3 selective clear with two bits set
        pulse(16'h000C);
        wr(2'd0, 16'hFFF7);
        rd(2'd0, d); check("R3 selective clear", d, 16'h0004);

        // R4 set wins over coincident clear of bit 3 (bit 2 clears)
        src_in = 16'h0008;
        cyc(2);
        wr(2'd0, 16'hFFF3);
        rd(2'd0, d); check("R4 set wins", d, 16'h0008);
        src_in = '0;
        cyc(3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule